// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block is a clocked master that runs an external successive-approximation converter over a parallel bus. On a host start request it opens the converter's chip select, pulses the conversion-start line, follows the converter's busy line through a two-flop synchronizer, and reads the result as two halves. A byte-select line chooses which half the converter presents. The halves are joined into one word and shown to the host for a single cycle with a valid strobe. The block then holds the bus quiet for a fixed number of cycles. That window covers the converter's acquisition time and the idle-bus rule that comes before the next sample.

The host can also abort a conversion in flight, reset the converter, or power it down. The power-down/reset line is active low, and the converter tells the two commands apart by the width of the low pulse: a short pulse resets it and a long one powers it down. After a power-down the block waits a configurable number of cycles before it accepts work again. Every timing limit is a parameter counted in system clock cycles, with the nanosecond limits rounded up for a 100 MHz clock.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While reset is applied and on the cycle after it is released, `adc_cs_n`, `adc_convst_n`, `adc_rd_n` and `adc_pd_n` are high, `adc_byte` is low, `result_valid` is low and `ready` is high.
- R2: A `start_req` sampled while `ready` is high pulls `adc_cs_n` low on that same clock edge. `adc_convst_n` falls T_EDGE cycles later and stays low for T_EDGE cycles. `adc_cs_n` stays low for T_HOLD more cycles after `adc_convst_n` rises, and `adc_convst_n` is only ever low while `adc_cs_n` is low.
- R3: After the controller sees `adc_busy` fall, it waits two synchronizer cycles, one decode cycle and T_DATA cycles. It then holds `adc_cs_n` and `adc_rd_n` low for 2*T_RD cycles. For the first T_RD of those cycles `adc_byte` is 0 and the bus carries the upper half of the result; for the second T_RD cycles `adc_byte` is 1 and the bus carries the lower half.
- R4: `result` equals {upper half, lower half}. `result_valid` is high for exactly one cycle, which is the first cycle in which `adc_rd_n` is high again.
- R5: `ready` returns exactly T_QUIET cycles after `result_valid`. `adc_convst_n` never falls unless `adc_rd_n` has been high, and `adc_convst_n` itself high, for at least T_QUIET cycles.
- R6: `ready` is low from the first cycle of a conversion until the quiet window ends. A `start_req` while `ready` is low is ignored: no second conversion-start pulse follows, and no further activity appears once `ready` returns.
- R7: If `abort_req` arrives during the start sequence or while waiting on busy, and busy is seen high with `adc_convst_n` high for T_ABT cycles, `adc_cs_n` pulses low for T_EDGE cycles with `adc_convst_n` high. No read follows and `result_valid` stays low. `ready` returns after busy falls and the quiet window has passed.
- R8: `abort_req` has no effect while idle or during the read. An idle abort leaves the bus pins and `ready` unchanged, and an abort during the read still delivers the full result.
- R9: A `reset_req` sampled while idle drives `adc_pd_n` low for exactly T_RST cycles. T_RST lies between the converter's reset minimum and the reset maximum T_RST_MAX. `ready` rises on the same cycle that `adc_pd_n` rises.
- R10: A `pwrdn_req` sampled while idle drives `adc_pd_n` low for at least T_PD cycles, and for longer while the request is held. `ready` rises exactly T_PWRUP cycles after `adc_pd_n` rises.
- R11: When several requests arrive together while idle, reset takes priority over power-down, and power-down takes priority over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request one conversion |
| abort_req | input | 1 | Abandon the conversion in flight |
| reset_req | input | 1 | Send a reset pulse to the converter |
| pwrdn_req | input | 1 | Power the converter down; the line stays low while this is held |
| result | output | RES_W | Assembled conversion word |
| result_valid | output | 1 | One-cycle strobe marking `result` |
| ready | output | 1 | Idle and able to accept a request |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_convst_n | output | 1 | Conversion start, falling edge samples |
| adc_rd_n | output | 1 | Read enable, active low |
| adc_byte | output | 1 | Half select: 0 upper, 1 lower |
| adc_pd_n | output | 1 | Power-down/reset, active low |
| adc_busy | input | 1 | Converter busy, asynchronous |
| adc_data | input | RES_W/2 | Converter data bus half |

## Verification
Every control pin is a register loaded from the next state, so each result appears at a fixed cycle. `adc_cs_n` falls on the same edge that samples start. The first read cycle comes four cycles after busy is seen low (two synchronizer stages, one decode cycle, one T_DATA cycle). The strobe comes 2*T_RD cycles after that, and `ready` comes T_QUIET cycles after the strobe. For a reset, `ready` rises on the same cycle `adc_pd_n` rises; after a power-down it rises T_PWRUP cycles later. The bench drives its inputs and samples the outputs one time step after each falling clock edge, numbers those samples from the request, and compares each difference between sample numbers with the exact count above, not with a window.

// File: rtl/adc_conv_sequencer.sv
`timescale 1ns/1ps
module adc_conv_sequencer #(
  parameter int RES_W     = 16,
  parameter int T_EDGE    = 2,
  parameter int T_HOLD    = 1,
  parameter int T_ABT     = 2,
  parameter int T_DATA    = 1,
  parameter int T_RD      = 3,
  parameter int T_QUIET   = 6,
  parameter int T_RST     = 10,
  parameter int T_RST_MAX = 614,
  parameter int T_PD      = 800,
  parameter int T_PWRUP   = 2500000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               abort_req,
  input  logic               reset_req,
  input  logic               pwrdn_req,
  output logic [RES_W-1:0]   result,
  output logic               result_valid,
  output logic               ready,
  output logic               adc_cs_n,
  output logic               adc_convst_n,
  output logic               adc_rd_n,
  output logic               adc_byte,
  output logic               adc_pd_n,
  input  logic               adc_busy,
  input  logic [RES_W/2-1:0] adc_data
);

  localparam int HALF_W = RES_W / 2;
  localparam int MAXC   = (T_PWRUP > T_PD) ? T_PWRUP : T_PD;
  localparam int CNT_W  = $clog2(MAXC + 1) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_CSLO, S_CVLO, S_REL, S_BUSY, S_DLY, S_RDH, S_RDL,
    S_ABT, S_ABTW, S_QUIET, S_RST, S_PD, S_PWRUP
  } state_t;

  state_t state, nxt;
  logic [CNT_W-1:0] cnt, lim;
  logic [HALF_W-1:0] hi_q;
  logic busy_m, busy_s, seen, abt_pend;
  logic hit, in_conv;

  always_comb begin
    unique case (state)
      S_CSLO, S_CVLO, S_ABT: lim = CNT_W'(T_EDGE - 1);
      S_REL:                 lim = CNT_W'(T_HOLD - 1);
      S_DLY:                 lim = CNT_W'(T_DATA - 1);
      S_RDH, S_RDL:          lim = CNT_W'(T_RD - 1);
      S_QUIET:               lim = CNT_W'(T_QUIET - 1);
      S_RST:                 lim = CNT_W'(T_RST - 1);
      S_PD:                  lim = CNT_W'(T_PD - 1);
      S_PWRUP:               lim = CNT_W'(T_PWRUP - 1);
      default:               lim = '0;
    endcase
  end

  assign hit     = (cnt >= lim);
  assign in_conv = (state inside {S_CSLO, S_CVLO, S_REL, S_BUSY});

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:
        if (reset_req)      nxt = S_RST;
        else if (pwrdn_req) nxt = S_PD;
        else if (start_req) nxt = S_CSLO;
      S_CSLO:  if (hit) nxt = S_CVLO;
      S_CVLO:  if (hit) nxt = S_REL;
      S_REL:   if (hit) nxt = S_BUSY;
      S_BUSY:
        if (abt_pend && busy_s && cnt >= CNT_W'(T_ABT - 1)) nxt = S_ABT;
        else if (seen && !busy_s)                             nxt = S_DLY;
      S_DLY:   if (hit) nxt = S_RDH;
      S_RDH:   if (hit) nxt = S_RDL;
      S_RDL:   if (hit) nxt = S_QUIET;
      S_ABT:   if (hit) nxt = S_ABTW;
      S_ABTW:  if (!busy_s) nxt = S_QUIET;
      S_QUIET: if (hit) nxt = S_IDLE;
      S_RST:   if (hit) nxt = S_IDLE;
      S_PD:    if (hit && !pwrdn_req) nxt = S_PWRUP;
      S_PWRUP: if (hit) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cnt          <= '0;
      busy_m       <= 1'b0;
      busy_s       <= 1'b0;
      seen         <= 1'b0;
      abt_pend     <= 1'b0;
      hi_q         <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      adc_cs_n     <= 1'b1;
      adc_convst_n <= 1'b1;
      adc_rd_n     <= 1'b1;
      adc_byte     <= 1'b0;
      adc_pd_n     <= 1'b1;
      ready        <= 1'b1;
    end else begin
      state    <= nxt;
      busy_m   <= adc_busy;
      busy_s   <= busy_m;
      if (nxt != state)    cnt <= '0;
      else if (cnt != '1)  cnt <= cnt + 1'b1;
      seen     <= (state == S_BUSY) ? (seen | busy_s) : 1'b0;
      abt_pend <= in_conv ? (abt_pend | abort_req) : 1'b0;
      if (state == S_RDH && hit) hi_q <= adc_data;
      result_valid <= (state == S_RDL) && hit;
      if (state == S_RDL && hit) result <= {hi_q, adc_data};
      adc_cs_n     <= !(nxt inside {S_CSLO, S_CVLO, S_REL, S_RDH, S_RDL, S_ABT});
      adc_convst_n <= (nxt != S_CVLO);
      adc_rd_n     <= !(nxt inside {S_RDH, S_RDL});
      adc_byte     <= (nxt == S_RDL);
      adc_pd_n     <= !(nxt inside {S_RST, S_PD});
      ready        <= (nxt == S_IDLE);
    end
  end

  logic [CNT_W-1:0] rd_idle, cv_hi, pd_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idle <= '1;
      cv_hi   <= '1;
      pd_lo   <= '0;
    end else begin
      if (!adc_rd_n)          rd_idle <= '0;
      else if (rd_idle != '1) rd_idle <= rd_idle + 1'b1;
      if (!adc_convst_n)      cv_hi <= '0;
      else if (cv_hi != '1)   cv_hi <= cv_hi + 1'b1;
      if (adc_pd_n)           pd_lo <= '0;
      else if (pd_lo != '1)   pd_lo <= pd_lo + 1'b1;
    end
  end

  AST_CONVST_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n) !adc_convst_n |-> !adc_cs_n); // R2
  AST_RD_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n) !adc_rd_n |-> !adc_cs_n); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) result_valid |=> !result_valid); // R4
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n) $fell(adc_convst_n) |-> rd_idle >= CNT_W'(T_QUIET)); // R5
  AST_ACQ_TIME: assert property (@(posedge clk) disable iff (!rst_n) $fell(adc_convst_n) |-> cv_hi >= CNT_W'(T_QUIET)); // R5
  AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) ready |-> (adc_cs_n && adc_rd_n && adc_convst_n && adc_pd_n)); // R6
  AST_PD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(adc_pd_n) |-> ((pd_lo >= CNT_W'(T_RST) && pd_lo <= CNT_W'(T_RST_MAX)) || pd_lo >= CNT_W'(T_PD))); // R9

endmodule

// File: tb/sim_adc_conv_sequencer.sv
`timescale 1ns/1ps
module sim_adc_conv_sequencer;
  localparam int PWRUP = 50;
  localparam int EDGE = 2, HOLD = 1, RD = 3, QUIET = 6, RSTW = 10, PDW = 800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_req = 1'b0, abort_req = 1'b0, reset_req = 1'b0, pwrdn_req = 1'b0;
  logic [15:0] result;
  logic result_valid, ready, cs_n, cv_n, rd_n, byt, pd_n;
  logic busy = 1'b0;
  logic [7:0] data;
  logic [15:0] adc_word = 16'h0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_conv_sequencer #(.T_PWRUP(PWRUP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .abort_req(abort_req),
    .reset_req(reset_req), .pwrdn_req(pwrdn_req), .result(result),
    .result_valid(result_valid), .ready(ready), .adc_cs_n(cs_n),
    .adc_convst_n(cv_n), .adc_rd_n(rd_n), .adc_byte(byt), .adc_pd_n(pd_n),
    .adc_busy(busy), .adc_data(data)
  );

  assign data = (!cs_n && !rd_n) ? (byt ? adc_word[7:0] : adc_word[15:8]) : 8'hA5;

  int dly = 0, left = 0, aborts = 0;
  logic cs_p = 1'b1, cv_p = 1'b1;
  always @(negedge clk) begin
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin busy = 1'b1; left = 15; end
    end else if (busy) begin
      if (cs_p && !cs_n && cv_n) begin busy = 1'b0; aborts++; end
      else begin left--; if (left == 0) busy = 1'b0; end
    end
    if (cv_p && !cv_n && !cs_n) dly = 2;
    cs_p = cs_n;
    cv_p = cv_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  int cs_pre, cv_lo, cv_falls, cs_hold, abt_lo, rd_lo, byte_hi, first_byte;
  int rd_first, bfall, v_cnt, v_cyc, v_rd, end_cyc, rdy1;
  logic [15:0] v_res;

  task automatic observe(input int poke_s, input int poke_a);
    bit hold_done = 0;
    logic cvq = 1'b1, bq = 1'b0;
    cs_pre = 0; cv_lo = 0; cv_falls = 0; cs_hold = 0; abt_lo = 0; rd_lo = 0;
    byte_hi = 0; first_byte = -1; rd_first = -1; bfall = -1; v_cnt = 0;
    v_cyc = -1; v_rd = -1; end_cyc = -1; rdy1 = -1; v_res = '0;
    for (int i = 1; i <= 300; i++) begin
      tick();
      start_req = (i == poke_s);
      abort_req = (i == poke_a);
      if (i == 1) rdy1 = ready;
      if (!cv_n) begin if (cvq) cv_falls++; cv_lo++; end
      if (!cs_n && cv_n && rd_n) begin
        if (cv_falls == 0) cs_pre++;
        else if (!hold_done) cs_hold++;
        else abt_lo++;
      end
      if (cv_falls > 0 && cs_n) hold_done = 1;
      if (bq && !busy) bfall = i;
      if (!rd_n) begin
        rd_lo++;
        if (byt) byte_hi++;
        if (rd_lo == 1) begin first_byte = byt; rd_first = i; end
      end
      if (result_valid) begin v_cnt++; v_res = result; v_cyc = i; v_rd = rd_n; end
      cvq = cv_n;
      bq = busy;
      if (ready) begin end_cyc = i; break; end
    end
    start_req = 0;
    abort_req = 0;
  endtask

  task automatic t_reset_state();
    chk(cs_n && cv_n && rd_n && pd_n, "R1 pins high in reset", {cs_n, cv_n, rd_n, pd_n}, 15);
    chk(!byt && !result_valid && ready, "R1 byte/valid/ready in reset", {byt, result_valid, ready}, 1);
    rst_n = 1'b1;
    tick();
    chk(cs_n && cv_n && rd_n && pd_n && !byt && ready && !result_valid, "R1 state after release", {cs_n, ready}, 3);
  endtask

  task automatic t_single(input logic [15:0] w, input string tag);
    adc_word = w;
    start_req = 1'b1;
    observe(0, 0);
    chk(rdy1 == 0, {"R6 ready low in conversion ", tag}, rdy1, 0);
    chk(cs_pre == EDGE, {"R2 cs before convst ", tag}, cs_pre, EDGE);
    chk(cv_lo == EDGE && cv_falls == 1, {"R2 convst width ", tag}, cv_lo, EDGE);
    chk(cs_hold == HOLD, {"R2 cs hold ", tag}, cs_hold, HOLD);
    chk(rd_first - bfall == 4, {"R3 busy fall to read ", tag}, rd_first - bfall, 4);
    chk(rd_lo == 2 * RD && byte_hi == RD && first_byte == 0, {"R3 read halves ", tag}, rd_lo * 10 + byte_hi, 2 * RD * 10 + RD);
    chk(v_cnt == 1 && v_rd == 1 && v_cyc == rd_first + 2 * RD, {"R4 strobe timing ", tag}, v_cyc, rd_first + 2 * RD);
    chk(v_res == w, {"R4 result word ", tag}, v_res, w);
    chk(end_cyc - v_cyc == QUIET, {"R5 quiet window ", tag}, end_cyc - v_cyc, QUIET);
  endtask

  task automatic t_start_ignored(input int poke);
    adc_word = 16'h3C5A;
    start_req = 1'b1;
    observe(poke, 0);
    chk(cv_falls == 1 && v_cnt == 1, "R6 start ignored while busy", cv_falls * 10 + v_cnt, 11);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(cs_n && cv_n && ready, "R6 no deferred start", {cs_n, cv_n, ready}, 7);
    end
  endtask

  task automatic t_abort();
    int a0 = aborts;
    adc_word = 16'hDEAD;
    start_req = 1'b1;
    observe(0, 3);
    chk(aborts == a0 + 1 && abt_lo == EDGE, "R7 abort cs pulse", abt_lo, EDGE);
    chk(rd_lo == 0 && v_cnt == 0, "R7 no read no valid", rd_lo + v_cnt, 0);
    chk(end_cyc > 0, "R7 ready returns", end_cyc, 1);
  endtask

  task automatic t_abort_late();
    adc_word = 16'h1234;
    start_req = 1'b1;
    observe(0, 26);
    chk(abt_lo == 0 && v_cnt == 1 && v_res == 16'h1234, "R8 abort in read ignored", v_res, 16'h1234);
  endtask

  task automatic t_abort_idle();
    abort_req = 1'b1;
    tick();
    abort_req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(ready && cs_n && rd_n && cv_n && pd_n, "R8 idle abort ignored", {ready, cs_n}, 3);
    end
  endtask

  int pd_cnt, rise_i, rdy_i, cs_seen, rdy_in_low;
  task automatic pd_run(input int hold, input bit r, input bit p, input bit s);
    bit was_low = 0;
    pd_cnt = 0; rise_i = -1; rdy_i = -1; cs_seen = 0; rdy_in_low = 0;
    reset_req = r; pwrdn_req = p; start_req = s;
    for (int i = 1; i <= 3000; i++) begin
      tick();
      if (i >= hold) begin reset_req = 0; pwrdn_req = 0; start_req = 0; end
      if (!cs_n) cs_seen++;
      if (!pd_n) begin pd_cnt++; was_low = 1; if (ready) rdy_in_low++; end
      else if (was_low && rise_i < 0) rise_i = i;
      if (ready && was_low) begin rdy_i = i; break; end
    end
  endtask

  task automatic t_reset_pulse();
    pd_run(1, 1, 0, 0);
    chk(pd_cnt == RSTW, "R9 reset pulse width", pd_cnt, RSTW);
    chk(rdy_i == rise_i && rdy_in_low == 0, "R9 ready with release", rdy_i, rise_i);
  endtask

  task automatic t_powerdown(input int hold, input int exp_w);
    pd_run(hold, 0, 1, 0);
    chk(pd_cnt == exp_w, "R10 power-down width", pd_cnt, exp_w);
    chk(rdy_i - rise_i == PWRUP, "R10 power-up wait", rdy_i - rise_i, PWRUP);
  endtask

  task automatic t_priority();
    pd_run(1, 1, 1, 1);
    chk(pd_cnt == RSTW && cs_seen == 0, "R11 reset wins", pd_cnt, RSTW);
    pd_run(1, 0, 1, 1);
    chk(pd_cnt == PDW && cs_seen == 0, "R11 power-down beats start", pd_cnt, PDW);
  endtask

  initial begin
    repeat (3) tick();
    t_reset_state();
    t_single(16'hA55A, "a");
    t_single(16'h00FF, "b");
    t_single(16'hFF00, "c");
    t_start_ignored(10);
    t_start_ignored(26);
    t_start_ignored(33);
    t_abort();
    t_abort_late();
    t_abort_idle();
    t_reset_pulse();
    t_powerdown(1, PDW);
    t_powerdown(1000, 1000);
    t_priority();
    t_single(16'h8001, "d");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule